// File: doc/BRIEF.md
# Floating-Point Compare Condition Queue

This block keeps the condition bits of a 32-bit floating-point status word up to date as compare results arrive. An external comparator reports each compare as a one-hot relation code (greater, less, equal or unordered), together with a five-bit condition selector and a four-bit target field. The selector decides which relations make the compare true. The result is a single bit: it is set when the selector bit for the reported relation is set.

A target field of zero means a queued compare. The history of earlier results in the queue region moves down by one place. The previous current-condition bit joins the top of the queue. The new result becomes the current-condition bit. A non-zero target field means a targeted compare, which writes the result into one addressed queue bit and leaves every other bit alone.

Compares that cannot be honoured are rejected without touching the status word and raise a one-cycle error pulse. A compare is rejected when its relation code is not one-hot or its target addresses a bit below the queue. The signaling-versus-quiet choice carried in the selector is handed on through an output and has no other effect.

Top module: `fcc_queue_top`

## Requirements
- R1: After a synchronous active-high reset, `status_o` is all zeros, and `err_o` and `signaling_o` are low.
- R2: `cmp_rel` is one-hot with bit 3 = greater, bit 2 = less, bit 1 = equal and bit 0 = unordered. The compare result equals `cmp_sel[4]` for greater, `cmp_sel[3]` for less, `cmp_sel[2]` for equal and `cmp_sel[1]` for unordered.
- R3: A queued compare (`cmp_y` = 0) updates the status word as follows. Bits [20:11] receive the old bits [21:12]. Bit 21 receives the old bit 26. Bit 26 receives the result. All other bits keep their value.
- R4: A targeted compare with `cmp_y` in 1..11 writes the result into status bit 22 - `cmp_y` and changes no other bit.
- R5: A compare with `cmp_y` in 12..15 is rejected. The status word is unchanged and `err_o` is high in the following cycle.
- R6: A compare whose `cmp_rel` is not one-hot (zero, or two or more bits set) is rejected. The status word is unchanged and `err_o` is high in the following cycle.
- R7: An accepted compare sampled at a clock edge is visible on `status_o` right after that edge. Without `cmp_valid`, `status_o` holds.
- R8: `signaling_o` holds `cmp_sel[0]` of the most recent accepted compare (1 = signaling, 0 = quiet). Rejected compares leave it unchanged.
- R9: `err_o` is high for exactly the cycle after a rejected compare and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Compare result present this cycle |
| cmp_rel | input | 4 | One-hot relation: 3 greater, 2 less, 1 equal, 0 unordered |
| cmp_sel | input | 5 | Condition selector; bits 4..1 pick relations, bit 0 = signaling |
| cmp_y | input | 4 | 0 = queued update, 1..11 = targeted bit 22 - y |
| status_o | output | 32 | Floating-point status word |
| signaling_o | output | 1 | Signaling flag of the last accepted compare |
| err_o | output | 1 | One-cycle pulse after a rejected compare |

## Verification
Each directed queued compare places a distinct result into the current bit. A run of such compares therefore shows whether the queue shifts by exactly one, drops the oldest entry and takes in the old current bit. Targeted writes at y = 1 and y = 11 hit the two ends of the queue, and y = 12 is the first rejected target. Zero and two-hot relation codes check the rejection path. All four relations are applied under selectors that differ in one bit, which separates a wrong selector bit from a wrong relation decode. Back-to-back random compares with mixed modes and idle gaps then compare the whole status word every cycle against a bench model.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    localparam int REL_W = 4;
    localparam int SEL_W = 5;

    // bit position of each relation inside the one-hot code
    typedef enum logic [1:0] {
        REL_UNORD = 2'd0,
        REL_EQ    = 2'd1,
        REL_LT    = 2'd2,
        REL_GT    = 2'd3
    } rel_idx_e;

    // decoded compare command
    typedef struct packed {
        logic hit;        // accepted compare
        logic queued;     // queued (shift) update
        logic result;     // selected compare outcome
        logic signaling;  // signaling compare requested
        logic reject;     // compare refused
    } fcc_cmd_t;

    function automatic logic rel_is_onehot(input logic [REL_W-1:0] r);
        return (r != '0) && ((r & (r - 1'b1)) == '0);
    endfunction

    // relation bit i is qualified by selector bit i+1
    function automatic logic pick_result(input logic [REL_W-1:0] r,
                                         input logic [SEL_W-1:0] s);
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < REL_W; i++) begin
            acc = acc | (r[i] & s[i+1]);
        end
        return acc;
    endfunction

endpackage

// File: rtl/fcc_decode.sv
module fcc_decode
    import fcc_pkg::*;
#(
    parameter int Y_W   = 4,
    parameter int Q_TOP = 21,
    parameter int Q_LEN = 11,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic [REL_W-1:0] rel_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [Y_W-1:0]   y_i,
    output fcc_cmd_t         cmd_o,
    output logic [IDX_W-1:0] tgt_idx_o
);

    logic rel_ok;
    logic y_ok;

    always_comb begin
        rel_ok = rel_is_onehot(rel_i);
        y_ok   = (int'(y_i) <= Q_LEN);

        cmd_o.queued    = (y_i == '0);
        cmd_o.result    = pick_result(rel_i, sel_i);
        cmd_o.signaling = sel_i[0];
        cmd_o.hit       = valid_i & rel_ok & y_ok;
        cmd_o.reject    = valid_i & ~(rel_ok & y_ok);

        tgt_idx_o = IDX_W'(Q_TOP + 1 - int'(y_i));
    end

    // R9: a compare is never both accepted and refused
    always_comb begin
        if (!rst) begin
            assert_hit_xor_reject_R9: assert (!(cmd_o.hit && cmd_o.reject));
        end
    end

    // R5: an out-of-range target is never accepted
    assert_far_target_refused_R5: assert property (@(posedge clk) disable iff (rst)
        (valid_i && int'(y_i) > Q_LEN) |-> cmd_o.reject);

endmodule

// File: rtl/fcc_next.sv
module fcc_next
    import fcc_pkg::*;
#(
    parameter int STATUS_W = 32,
    parameter int CUR_BIT  = 26,
    parameter int Q_TOP    = 21,
    parameter int Q_LEN    = 11,
    parameter int IDX_W    = 5
) (
    input  logic [STATUS_W-1:0] cur_i,
    input  fcc_cmd_t            cmd_i,
    input  logic [IDX_W-1:0]    tgt_idx_i,
    output logic [STATUS_W-1:0] nxt_o
);

    localparam int Q_BOT = Q_TOP - Q_LEN + 1;

    logic do_queue;
    logic do_target;

    always_comb begin
        do_queue  = cmd_i.hit & cmd_i.queued;
        do_target = cmd_i.hit & ~cmd_i.queued;
    end

    for (genvar b = 0; b < STATUS_W; b++) begin : g_bit
        if (b == CUR_BIT) begin : g_cur
            always_comb nxt_o[b] = do_queue ? cmd_i.result : cur_i[b];
        end else if (b == Q_TOP) begin : g_qtop
            always_comb begin
                if (do_queue)
                    nxt_o[b] = cur_i[CUR_BIT];
                else if (do_target && tgt_idx_i == IDX_W'(b))
                    nxt_o[b] = cmd_i.result;
                else
                    nxt_o[b] = cur_i[b];
            end
        end else if (b >= Q_BOT && b < Q_TOP) begin : g_qbody
            always_comb begin
                if (do_queue)
                    nxt_o[b] = cur_i[b+1];
                else if (do_target && tgt_idx_i == IDX_W'(b))
                    nxt_o[b] = cmd_i.result;
                else
                    nxt_o[b] = cur_i[b];
            end
        end else begin : g_keep
            always_comb nxt_o[b] = cur_i[b];
        end
    end

endmodule

// File: rtl/fcc_queue_top.sv
module fcc_queue_top
    import fcc_pkg::*;
#(
    parameter int STATUS_W = 32,
    parameter int CUR_BIT  = 26,
    parameter int Q_TOP    = 21,
    parameter int Q_LEN    = 11,
    parameter int Y_W      = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmp_valid,
    input  logic [3:0]          cmp_rel,
    input  logic [4:0]          cmp_sel,
    input  logic [Y_W-1:0]      cmp_y,
    output logic [STATUS_W-1:0] status_o,
    output logic                signaling_o,
    output logic                err_o
);

    localparam int IDX_W = $clog2(STATUS_W);

    fcc_cmd_t            cmd;
    logic [IDX_W-1:0]    tgt_idx;
    logic [STATUS_W-1:0] status_q;
    logic [STATUS_W-1:0] status_d;
    logic                sig_q;
    logic                err_q;

    fcc_decode #(
        .Y_W   (Y_W),
        .Q_TOP (Q_TOP),
        .Q_LEN (Q_LEN),
        .IDX_W (IDX_W)
    ) u_decode (
        .clk       (clk),
        .rst       (rst),
        .valid_i   (cmp_valid),
        .rel_i     (cmp_rel),
        .sel_i     (cmp_sel),
        .y_i       (cmp_y),
        .cmd_o     (cmd),
        .tgt_idx_o (tgt_idx)
    );

    fcc_next #(
        .STATUS_W (STATUS_W),
        .CUR_BIT  (CUR_BIT),
        .Q_TOP    (Q_TOP),
        .Q_LEN    (Q_LEN),
        .IDX_W    (IDX_W)
    ) u_next (
        .cur_i     (status_q),
        .cmd_i     (cmd),
        .tgt_idx_i (tgt_idx),
        .nxt_o     (status_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            sig_q    <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            status_q <= status_d;
            err_q    <= cmd.reject;
            if (cmd.hit) sig_q <= cmd.signaling;
        end
    end

    assign status_o    = status_q;
    assign signaling_o = sig_q;
    assign err_o       = err_q;

    // R7: no strobe, no change
    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
        !cmp_valid |=> $stable(status_o));

    // R6: a non-one-hot relation leaves the word alone and flags an error
    assert_bad_rel_R6: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && !$onehot(cmp_rel)) |=> ($stable(status_o) && err_o));

    // R3: queued compare moves the old current bit to the queue top
    assert_queue_top_R3: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && $onehot(cmp_rel) && cmp_y == '0)
            |=> status_o[Q_TOP] == $past(status_o[CUR_BIT]));

    // R4: targeted compare flips at most one bit
    assert_target_single_R4: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && $onehot(cmp_rel) && cmp_y != '0 && int'(cmp_y) <= Q_LEN)
            |=> $countones(status_o ^ $past(status_o)) <= 1);

    // R8: signaling flag follows the accepted compare
    assert_signal_follow_R8: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && $onehot(cmp_rel) && int'(cmp_y) <= Q_LEN)
            |=> signaling_o == $past(cmp_sel[0]));

    // R9: no error without a strobe
    assert_err_needs_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        !cmp_valid |=> !err_o);

endmodule

// File: tb/fcc_queue_top_tb.sv
module fcc_queue_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmp_valid;
    logic [3:0]  cmp_rel;
    logic [4:0]  cmp_sel;
    logic [3:0]  cmp_y;
    logic [31:0] status_o;
    logic        signaling_o;
    logic        err_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_status;
    logic        m_sig;
    logic        m_err;

    always #10 clk = ~clk;

    fcc_queue_top u_dut (
        .clk         (clk),
        .rst         (rst),
        .cmp_valid   (cmp_valid),
        .cmp_rel     (cmp_rel),
        .cmp_sel     (cmp_sel),
        .cmp_y       (cmp_y),
        .status_o    (status_o),
        .signaling_o (signaling_o),
        .err_o       (err_o)
    );

    function automatic logic f_onehot(input logic [3:0] r);
        return (r == 4'b0001) || (r == 4'b0010) || (r == 4'b0100) || (r == 4'b1000);
    endfunction

    function automatic logic f_result(input logic [3:0] r, input logic [4:0] s);
        case (r)
            4'b1000: return s[4];
            4'b0100: return s[3];
            4'b0010: return s[2];
            default: return s[1];
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // model update for one strobe
    task automatic model(input logic [3:0] r, input logic [4:0] s, input logic [3:0] y);
        logic res;
        logic [31:0] o;
        o = m_status;
        if (!f_onehot(r) || y > 4'd11) begin
            m_err = 1'b1;
        end else begin
            m_err = 1'b0;
            m_sig = s[0];
            res = f_result(r, s);
            if (y == 4'd0) begin
                m_status[20:11] = o[21:12];
                m_status[21]    = o[26];
                m_status[26]    = res;
            end else begin
                m_status[22 - int'(y)] = res;
            end
        end
    endtask

    task automatic cmp(input logic [3:0] r, input logic [4:0] s, input logic [3:0] y,
                       input string tag);
        cmp_valid = 1'b1; cmp_rel = r; cmp_sel = s; cmp_y = y;
        model(r, s, y);
        @(negedge clk);
        chk({tag, " status"}, status_o, m_status);
        chk({tag, " err"}, {31'd0, err_o}, {31'd0, m_err});
        chk({tag, " signaling"}, {31'd0, signaling_o}, {31'd0, m_sig});
    endtask

    task automatic idle(input string tag);
        cmp_valid = 1'b0;
        m_err = 1'b0;
        @(negedge clk);
        chk({tag, " status hold"}, status_o, m_status);
        chk({tag, " err low"}, {31'd0, err_o}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        int unused;
        unused = $urandom(32'd1234);
        rst = 1'b1; cmp_valid = 1'b0; cmp_rel = '0; cmp_sel = '0; cmp_y = '0;
        m_status = '0; m_sig = 1'b0; m_err = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 status", status_o, 32'd0);
        chk("R1 err", {31'd0, err_o}, 32'd0);
        chk("R1 signaling", {31'd0, signaling_o}, 32'd0);

        // R2: each relation against selectors differing in one bit
        cmp(4'b1000, 5'b10000, 4'd0, "R2 gt sel4");
        cmp(4'b1000, 5'b01110, 4'd0, "R2 gt not sel4");
        cmp(4'b0100, 5'b01000, 4'd0, "R2 lt sel3");
        cmp(4'b0100, 5'b10110, 4'd0, "R2 lt not sel3");
        cmp(4'b0010, 5'b00101, 4'd0, "R2 eq sel2 R8 signaling");
        cmp(4'b0010, 5'b11010, 4'd0, "R2 eq not sel2");
        cmp(4'b0001, 5'b00010, 4'd0, "R2 unord sel1");
        cmp(4'b0001, 5'b11101, 4'd0, "R2 unord not sel1");
        // R3: longer queued run so the oldest entries fall off bit 11
        for (int i = 0; i < 14; i++)
            cmp(4'b0010, (i % 3 == 0) ? 5'b00100 : 5'b00000, 4'd0, "R3 queued run");
        idle("R7 idle");
        // R4: queue ends
        cmp(4'b1000, 5'b10000, 4'd1, "R4 target y1");
        cmp(4'b1000, 5'b10000, 4'd11, "R4 target y11");
        cmp(4'b1000, 5'b00000, 4'd1, "R4 target y1 clear");
        // R5: first rejected target, signaling must stay
        cmp(4'b1000, 5'b10001, 4'd12, "R5 target y12");
        cmp(4'b1000, 5'b10001, 4'd15, "R5 target y15");
        idle("R9 err drops");
        // R6: bad relations
        cmp(4'b0000, 5'b11111, 4'd0, "R6 rel zero");
        cmp(4'b0011, 5'b11111, 4'd3, "R6 rel two-hot");
        idle("R9 err drops after R6");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] r;
            logic [3:0] y;
            logic [4:0] s;
            s = 5'($urandom);
            r = ($urandom % 8 == 0) ? 4'($urandom) : (4'b0001 << ($urandom % 4));
            y = ($urandom % 2 == 0) ? 4'd0 : 4'($urandom);
            if ($urandom % 5 == 0) idle("R7 random idle");
            else cmp(r, s, y, "R3 R4 R5 R6 R8 random");
        end

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; cmp_valid = 1'b0;
        m_status = '0; m_sig = 1'b0;
        @(negedge clk);
        chk("R1 re-reset status", status_o, 32'd0);
        chk("R1 re-reset signaling", {31'd0, signaling_o}, 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule